// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block generates the running count that a PWM generator compares against. A base clock passes through two dividers in series: a power-of-two stage and an even-step stage. Each divided tick advances a 16-bit counter. The counter runs in one of four modes: up, down, up-down (triangle) or hold. It turns around or wraps at a programmable period value.

Software programs the block through a small 16-bit register port: a control word, a period register and a phase register. The current count and direction can be read back. A sync input can load the phase value into the counter, so several time bases can be aligned. A selectable sync output lets such a load be passed on to the next block.

The block drives four outputs:
- the count;
- a flag that is high while the count is zero;
- a flag that is high while the count equals the period;
- the present count direction.

Top module: `pwmtb_timebase`

## Requirements
- R1: While reset is held, the count is 0, `dir_up` is 1, `zero_match` is 1, the control word reads 0x0000, the period reads 0xFFFF and the phase reads 0x0000.
- R2: The counter advances once every D base-clock cycles. D = 2^n × h, where n is control bits 12:10, and h is 1 when control bits 9:7 are zero and twice that field otherwise. A control write restarts the divider.
- R3: In up mode (control bits 1:0 = 0), each tick moves the count from c to c+1 while c is below the period P. When c is P or above, the next tick sets the count to 0, so a cycle lasts P+1 ticks. `dir_up` is 1 in this mode.
- R4: In down mode (bits 1:0 = 1), each tick decrements the count. A tick at count 0 loads P. `dir_up` is 0 in this mode.
- R5: In up-down mode (bits 1:0 = 2), the count climbs to P and then falls to 0, so a full triangle lasts 2P ticks. `dir_up` reads 1 on the way up, including at P. It reads 0 on the way down, including at 0. With P = 0 the count stays at 0.
- R6: In hold mode (bits 1:0 = 3), the count does not change, except through a phase load.
- R7: `zero_match` is high exactly while the count is 0. `prd_match` is high exactly while the count equals the period register.
- R8: When control bit 2 is 1, a clock edge with `sync_in` high loads the phase register into the count. This load takes priority over every mode. Control bit 13 sets the stored direction (1 = up). When bit 2 is 0, `sync_in` has no effect on the count.
- R9: Control bits 5:4 select `sync_out`: 0 passes `sync_in`, 1 gives `zero_match`, 2 gives `prd_match`, and 3 holds it low.
- R10: The registers are at byte offsets 0x00 (control), 0x02 (status), 0x06 (phase), 0x08 (count) and 0x0A (period). The control word, phase and period read back exactly as written, including control bits 15:14, which have no effect. Status bit 0 reads `dir_up`. The count offset reads the live count. Writes to the count and status offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sync_in | input | 1 | Phase-load request |
| count | output | 16 | Current time-base count |
| zero_match | output | 1 | High while count is 0 |
| prd_match | output | 1 | High while count equals the period |
| dir_up | output | 1 | Current direction, 1 = up |
| sync_out | output | 1 | Selected sync output |

## Verification
The assertions are checked on every cycle. They cover the one-step laws of the counter:
- an up step below the period adds one;
- a down step from zero reloads the period;
- the up-down turnaround at the top clears the direction;
- hold mode keeps the count stable;
- a phase load lands the phase value;
- the divided tick never fires on back-to-back cycles when the ratio exceeds one.

Whole waveform shapes can only be shown by the bench scenarios. These are the wrap and triangle sequences over a sweep of periods, the exact divider intervals for many prescaler settings, the reaction to a period shrunk below the count, sync gating and routing, and register read-back.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

  localparam int REG_W  = 16;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 5;
  localparam int PRE1_W = 3;
  localparam int PRE2_W = 3;
  localparam int PRE1_MAX_SHIFT = (1 << PRE1_W) - 1;
  localparam int PRE2_MAX_RATIO = 2 * ((1 << PRE2_W) - 1);
  localparam int DIV_W = PRE1_MAX_SHIFT + $clog2(PRE2_MAX_RATIO + 1);

  // control word field positions
  localparam int F_MODE_LO  = 0;
  localparam int F_LOAD_EN  = 2;
  localparam int F_SYNC_LO  = 4;
  localparam int F_HS_LO    = 7;
  localparam int F_PRE_LO   = 10;
  localparam int F_LOAD_DIR = 13;

  // register byte offsets
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h02;
  localparam logic [ADDR_W-1:0] A_PHASE  = 5'h06;
  localparam logic [ADDR_W-1:0] A_COUNT  = 5'h08;
  localparam logic [ADDR_W-1:0] A_PERIOD = 5'h0A;

  localparam logic [REG_W-1:0] CTRL_RST   = 16'h0000;
  localparam logic [REG_W-1:0] PERIOD_RST = 16'hFFFF;
  localparam logic [REG_W-1:0] PHASE_RST  = 16'h0000;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_HOLD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SYNC_PASS = 2'd0,
    SYNC_ZERO = 2'd1,
    SYNC_PRD  = 2'd2,
    SYNC_OFF  = 2'd3
  } sync_sel_e;

  typedef struct packed {
    logic [CNT_W-1:0] value;
    logic             up;
  } cnt_state_t;

  // total division: (2^n) * (h == 0 ? 1 : 2h)
  function automatic logic [DIV_W-1:0] prescale_ratio(
    input logic [PRE1_W-1:0] n,
    input logic [PRE2_W-1:0] h
  );
    logic [DIV_W-1:0] hs;
    if (h == '0) hs = DIV_W'(1);
    else         hs = DIV_W'({h, 1'b0});
    return hs << n;
  endfunction

  // one tick of the time base
  function automatic cnt_state_t next_count(
    input cnt_mode_e        m,
    input logic [CNT_W-1:0] c,
    input logic [CNT_W-1:0] p,
    input logic             up
  );
    cnt_state_t s;
    s.value = c;
    s.up    = up;
    case (m)
      MODE_UP: begin
        s.up    = 1'b1;
        s.value = (c >= p) ? '0 : c + CNT_W'(1);
      end
      MODE_DOWN: begin
        s.up    = 1'b0;
        s.value = (c == '0) ? p : c - CNT_W'(1);
      end
      MODE_UPDOWN: begin
        if (p == '0) begin
          s.value = '0;
        end else if (up) begin
          if (c >= p) begin
            s.up    = 1'b0;
            s.value = c - CNT_W'(1);
          end else begin
            s.value = c + CNT_W'(1);
          end
        end else begin
          if (c == '0) begin
            s.up    = 1'b1;
            s.value = CNT_W'(1);
          end else begin
            s.value = c - CNT_W'(1);
          end
        end
      end
      default: begin
        s.value = c;
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwmtb_prescaler.sv
module pwmtb_prescaler
  import pwmtb_pkg::*;
#(
  parameter int RATIO_W = DIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);

  logic [RATIO_W-1:0] div_cnt;
  logic [RATIO_W-1:0] last_val;

  assign last_val = (ratio == '0) ? '0 : ratio - RATIO_W'(1);
  assign tick     = (div_cnt >= last_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
    end else if (restart || tick) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + RATIO_W'(1);
    end
  end

endmodule

// File: rtl/pwmtb_regs.sv
module pwmtb_regs
  import pwmtb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] period_q,
  output logic [DW-1:0] phase_q,
  output logic          ctrl_wr
);

  logic period_wr;
  logic phase_wr;

  assign ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
  assign period_wr = bus_wr && (bus_addr == A_PERIOD);
  assign phase_wr  = bus_wr && (bus_addr == A_PHASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      period_q <= PERIOD_RST;
      phase_q  <= PHASE_RST;
    end else begin
      if (ctrl_wr)   ctrl_q   <= bus_wdata;
      if (period_wr) period_q <= bus_wdata;
      if (phase_wr)  phase_q  <= bus_wdata;
    end
  end

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
  import pwmtb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] phase,
  input  logic             load_fire,
  input  logic             load_dir,
  output logic [CNT_W-1:0] count,
  output logic             dir_q
);

  cnt_state_t step;

  always_comb begin
    step = next_count(mode, count, period, dir_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      dir_q <= 1'b1;
    end else if (load_fire) begin
      count <= phase;
      dir_q <= load_dir;
    end else if (tick) begin
      count <= step.value;
      dir_q <= step.up;
    end
  end

endmodule

// File: rtl/pwmtb_timebase.sv
module pwmtb_timebase
  import pwmtb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              sync_in,
  output logic [CNT_W-1:0]  count,
  output logic              zero_match,
  output logic              prd_match,
  output logic              dir_up,
  output logic              sync_out
);

  logic [REG_W-1:0]  ctrl_q;
  logic [REG_W-1:0]  period_q;
  logic [REG_W-1:0]  phase_q;
  logic              ctrl_wr;
  logic              presc_tick;
  logic [DIV_W-1:0]  ratio;
  logic              ratio_one;
  logic              load_fire;
  logic              dir_q;
  cnt_mode_e         mode;
  sync_sel_e         sync_sel;
  logic [PRE1_W-1:0] pre_n;
  logic [PRE2_W-1:0] pre_h;

  pwmtb_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .period_q  (period_q),
    .phase_q   (phase_q),
    .ctrl_wr   (ctrl_wr)
  );

  assign mode      = cnt_mode_e'(ctrl_q[F_MODE_LO +: 2]);
  assign sync_sel  = sync_sel_e'(ctrl_q[F_SYNC_LO +: 2]);
  assign pre_n     = ctrl_q[F_PRE_LO +: PRE1_W];
  assign pre_h     = ctrl_q[F_HS_LO +: PRE2_W];
  assign ratio     = prescale_ratio(pre_n, pre_h);
  assign ratio_one = (ratio == DIV_W'(1));
  assign load_fire = ctrl_q[F_LOAD_EN] && sync_in;

  pwmtb_prescaler #(.RATIO_W(DIV_W)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr),
    .ratio   (ratio),
    .tick    (presc_tick)
  );

  pwmtb_counter i_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (presc_tick),
    .mode      (mode),
    .period    (period_q),
    .phase     (phase_q),
    .load_fire (load_fire),
    .load_dir  (ctrl_q[F_LOAD_DIR]),
    .count     (count),
    .dir_q     (dir_q)
  );

  always_comb begin
    case (mode)
      MODE_UP:   dir_up = 1'b1;
      MODE_DOWN: dir_up = 1'b0;
      default:   dir_up = dir_q;
    endcase
  end

  assign zero_match = (count == '0);
  assign prd_match  = (count == period_q);

  always_comb begin
    case (sync_sel)
      SYNC_PASS: sync_out = sync_in;
      SYNC_ZERO: sync_out = zero_match;
      SYNC_PRD:  sync_out = prd_match;
      default:   sync_out = 1'b0;
    endcase
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = ctrl_q;
      A_STAT:   bus_rdata = {{(REG_W-1){1'b0}}, dir_up};
      A_PHASE:  bus_rdata = phase_q;
      A_COUNT:  bus_rdata = count;
      A_PERIOD: bus_rdata = period_q;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwmtb_checker.sv
module pwmtb_checker
  import pwmtb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ratio_one,
  input logic             ctrl_wr,
  input cnt_mode_e        mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] phase,
  input logic             load_fire,
  input logic             dir_q
);

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ratio_one && !ctrl_wr) |=> !tick);

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UP && tick && !load_fire && count < period)
      |=> count == $past(count) + CNT_W'(1));

  assert_down_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DOWN && tick && !load_fire && count == '0)
      |=> count == $past(period));

  assert_turn_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_UPDOWN && tick && !load_fire && dir_q &&
     period != '0 && count >= period) |=> !dir_q);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD && !load_fire) |=> $stable(count));

  assert_phase_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> count == $past(phase));

endmodule

bind pwmtb_timebase pwmtb_checker i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (presc_tick),
  .ratio_one (ratio_one),
  .ctrl_wr   (ctrl_wr),
  .mode      (mode),
  .count     (count),
  .period    (period_q),
  .phase     (phase_q),
  .load_fire (load_fire),
  .dir_q     (dir_q)
);

// File: tb/test_pwmtb_timebase.sv
`timescale 1ns/1ps
module test_pwmtb_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sync_in = 1'b0;
  logic [15:0] count;
  logic        zero_match, prd_match, dir_up, sync_out;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwmtb_timebase i_pwmtb_timebase (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
    .count(count), .zero_match(zero_match), .prd_match(prd_match),
    .dir_up(dir_up), .sync_out(sync_out)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // align the counter to 0 with direction up using a phase load
  task automatic align_zero();
    wr(5'h06, 16'h0000);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic sweep(input int m, input int p, input string req);
    int e, t, ed;
    wr(5'h0A, 16'(p));
    wr(5'h00, 16'(m | 16'h0004 | 16'h2000 | 16'h0030));
    align_zero();
    for (int k = 0; k < 3 * (2 * p + 2); k++) begin
      if (k > 0) @(negedge clk);
      if (m == 0) begin
        e = k % (p + 1); ed = 1;
      end else if (m == 1) begin
        e = (p + 1 - (k % (p + 1))) % (p + 1); ed = 0;
      end else begin
        if (p == 0) begin e = 0; ed = 1; end
        else begin
          t = k % (2 * p);
          e = (t <= p) ? t : 2 * p - t;
          ed = (k == 0) ? 1 : ((t >= 1 && t <= p) ? 1 : 0);
        end
      end
      check(req, count, e);
      check("R7", zero_match, (e == 0) ? 1 : 0);
      check("R7", prd_match, (e == p) ? 1 : 0);
      check(req, dir_up, ed);
    end
  endtask

  task automatic div_check(input int n, input int h);
    int d, last, seen, prev, guard;
    d = ((h == 0) ? 1 : 2 * h) << n;
    wr(5'h0A, 16'hFFFF);
    wr(5'h00, 16'((n << 10) | (h << 7) | 16'h0030));
    last = -1; seen = 0; guard = 0;
    prev = count;
    while (seen < 3 && guard < 8 * d + 16) begin
      @(negedge clk);
      guard++;
      if (count != prev) begin
        if (last >= 0) begin
          check("R2", cyc - last, d);
          seen++;
        end
        last = cyc;
        prev = count;
      end
    end
    check("R2 interval count", seen, 3);
  endtask

  initial begin
    wait (cyc >= 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got %0d expected 0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r, c0;
    // R1: state during reset
    repeat (3) @(negedge clk);
    check("R1", count, 0);
    check("R1", dir_up, 1);
    check("R1", zero_match, 1);
    rd(5'h00, r); check("R1", r, 16'h0000);
    rd(5'h0A, r); check("R1", r, 16'hFFFF);
    rd(5'h06, r); check("R1", r, 16'h0000);
    @(negedge clk); rst_n = 1'b1;

    // R3, R4, R5 waveform sweeps over small periods
    for (int p = 0; p <= 6; p++) sweep(0, p, "R3");
    for (int p = 0; p <= 6; p++) sweep(1, p, "R4");
    for (int p = 0; p <= 6; p++) sweep(2, p, "R5");

    // R3: period shrunk below the count wraps to 0 on the next tick
    wr(5'h0A, 16'd200);
    wr(5'h00, 16'h0030);
    repeat (60) @(negedge clk);
    wr(5'h0A, 16'd10);
    @(negedge clk);
    check("R3 shrink", count, 0);

    // R2: divider intervals
    for (int n = 0; n <= 3; n++)
      for (int h = 0; h <= 3; h++) div_check(n, h);
    div_check(2, 5);
    div_check(7, 7);

    // R6: hold mode keeps the count
    wr(5'h0A, 16'd1000);
    wr(5'h00, 16'h0030);
    repeat (37) @(negedge clk);
    wr(5'h00, 16'h0033);
    c0 = count;
    repeat (30) @(negedge clk);
    check("R6", count, c0);

    // R10: count-register write ignored
    wr(5'h08, 16'h1234);
    rd(5'h08, r); check("R10 count write ignored", r, c0);
    wr(5'h02, 16'h0000);
    rd(5'h02, r); check("R10 status write ignored", r, 16'h0001);

    // R8: sync ignored with load disabled, honoured with it enabled
    wr(5'h06, 16'h0055);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    check("R8 gated", count, c0);
    wr(5'h00, 16'h0037);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    check("R8 load", count, 16'h0055);
    // load in up-down with direction bit 0 -> falls next
    wr(5'h00, 16'h0036);
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    check("R8 dir", dir_up, 0);
    @(negedge clk);
    check("R8 dir step", count, 16'h0054);

    // R9: sync output routing
    wr(5'h0A, 16'd3);
    wr(5'h00, 16'h0000);
    sync_in = 1'b1; #1;
    check("R9 pass", sync_out, 1);
    sync_in = 1'b0; #1;
    check("R9 pass", sync_out, 0);
    wr(5'h00, 16'h0010);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R9 zero", sync_out, (count == 0) ? 1 : 0);
    end
    wr(5'h00, 16'h0020);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R9 prd", sync_out, (count == 3) ? 1 : 0);
    end
    wr(5'h00, 16'h0030);
    sync_in = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R9 off", sync_out, 0);
    end
    sync_in = 1'b0;

    // R10: read-back and status
    wr(5'h06, 16'hBEEF);
    rd(5'h06, r); check("R10 phase", r, 16'hBEEF);
    wr(5'h0A, 16'h00C8);
    rd(5'h0A, r); check("R10 period", r, 16'h00C8);
    wr(5'h00, 16'h8031);
    rd(5'h00, r); check("R10 ctrl", r, 16'h8031);
    rd(5'h02, r); check("R10 status down", r, 16'h0000);
    @(negedge clk);
    rd(5'h08, r); check("R10 count read", r, count);
    wr(5'h00, 16'hC030);
    rd(5'h02, r); check("R10 status up", r, 16'h0001);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule